// File: doc/BRIEF.md
# Serial-Flash Bus Ownership Arbiter

This block chooses which of two requesters drives a shared serial-flash interface. One requester is a direct-command port that software programs one transfer at a time. The other is a read-acceleration engine that serves memory-mapped reads through a set of prefetch buffers. The arbiter drives the mux select for the flash chip-select, clock and data lines. It also raises per-buffer invalidate pulses and reports a busy status bit that software polls before it changes ownership.

Software states the owner it wants through a control bit. The arbiter moves the bus only when the current user is quiet. For the direct-command port that means no transfer is running and the write lock is clear. For the read engine it means no flash access is in flight. In both cases both chip-selects must be deasserted. Before the read engine gets the bus, every prefetch buffer is told to drop its contents, so that no stale data comes back. Separately, each buffer has a software flush bit, and a flush happens on the 0-to-1 change of that bit. Holding the bit at 1 does nothing more.

There is no streaming data path through this block, so every pin is a plain level or pulse with no handshake. All outputs except the busy bit are registered.

Top module: `flash_owner_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sel_eng_o` is 0, so the direct-command port owns the bus, and every bit of `inval_o` is 1. At the first clock edge after release, `inval_o` returns to 0 unless a flush or a handover asks for it.
- R2: A handover to the read engine takes two clock edges. The first edge must sample `own_cmd_i`=0, `wlock_i`=0, `cmd_busy_i`=0, `eng_busy_i`=0 and both chip-selects high. After that edge, `inval_o` is all ones for one cycle. If the same conditions hold at the next edge, `sel_eng_o` becomes 1 after it.
- R3: While the direct-command port owns the bus, `sel_eng_o` stays 0 at any edge that samples `cmd_busy_i`=1, `eng_busy_i`=1 or either chip-select low. A handover that is interrupted after the flush cycle falls back to direct-command ownership.
- R4: While the read engine owns the bus, `sel_eng_o` stays 1 at any edge that samples `eng_busy_i`=1 or either chip-select low. Otherwise, an edge that samples `own_cmd_i`=1 returns the bus to the direct-command port: `sel_eng_o` is 0 after that edge.
- R5: While `wlock_i` is 1, the direct-command port keeps the bus whatever the value of `own_cmd_i`.
- R6: When `flush_i[i]` is sampled 1 after being sampled 0 at the previous edge, `inval_o[i]` is 1 for exactly one cycle and no other bit is affected by that flush. Holding `flush_i[i]` at 1 or 0 produces no further pulses.
- R7: `busy_o` is 1 whenever `eng_busy_i` is 1 and during the flush cycle of a handover. At all other times it is 0.
- R8: `sel_eng_o` changes only after an edge at which both `cmd_cs_n_i` and `eng_cs_n_i` were sampled high.
- R9: `sel_eng_o` never rises unless `inval_o` was all ones in the cycle just before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_cmd_i | input | 1 | Requested owner: 1 selects the direct-command port, 0 selects the read engine |
| wlock_i | input | 1 | Write lock; while 1, the bus stays with the direct-command port |
| flush_i | input | NBUF | Per-buffer flush control bits; each acts on its rising edge |
| cmd_busy_i | input | 1 | Direct-command port has a transfer running |
| eng_busy_i | input | 1 | Read engine has a flash access in flight |
| cmd_cs_n_i | input | 1 | Chip-select of the direct-command port, active low |
| eng_cs_n_i | input | 1 | Chip-select of the read engine, active low |
| sel_eng_o | output | 1 | Mux select for the flash lines: 1 lets the read engine drive |
| busy_o | output | 1 | Busy status bit that software polls before changing ownership |
| inval_o | output | NBUF | One-cycle invalidate pulse for each prefetch buffer |

## Verification
Several rules are checked by assertions on every cycle. The mux select may only move after an edge at which both chip-selects were idle. It may only rise toward the read engine after a full invalidate cycle. It holds while the current owner is busy or write-locked. A single rising flush bit gives a single pulse.

Other behaviour can only be shown by the bench scenarios. These cover the exact reset values, and a handover cut short in its flush cycle that falls back to the direct-command port. They also show that a held flush level stays silent and that simultaneous flushes of both buffers each pulse. The busy bit is checked against a cycle-by-cycle reference model while it covers the flush cycle.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_ENG   = 2'd2
  } own_state_t;
endpackage

// File: rtl/flush_edge.sv
module flush_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic auto_i,
  output logic inval_o
);
  logic prev_q;
  logic inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      inv_q  <= 1'b1;
    end else begin
      prev_q <= flush_i;
      inv_q  <= (flush_i & ~prev_q) | auto_i;
    end
  end

  assign inval_o = inv_q;

  // R6: a level held high over two edges, with no handover flush, gives no pulse
  a_r6_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && prev_q && !auto_i) |=> !inval_o);
endmodule

// File: rtl/own_fsm.sv
module own_fsm
  import flash_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic own_cmd_i,
  input  logic wlock_i,
  input  logic cmd_busy_i,
  input  logic eng_busy_i,
  input  logic bus_idle_i,
  output logic auto_flush_o,
  output logic sel_eng_o,
  output logic flushing_o
);
  own_state_t state_q, state_d;
  logic go_eng, go_cmd;

  assign go_eng = !own_cmd_i && !wlock_i && !cmd_busy_i && !eng_busy_i && bus_idle_i;
  assign go_cmd = own_cmd_i && !eng_busy_i && bus_idle_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_CMD:   if (go_eng) state_d = ST_FLUSH;
      ST_FLUSH: state_d = go_eng ? ST_ENG : ST_CMD;
      ST_ENG:   if (go_cmd) state_d = ST_CMD;
      default:  state_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CMD;
    else        state_q <= state_d;
  end

  assign auto_flush_o = (state_q == ST_CMD) && go_eng;
  assign sel_eng_o    = (state_q == ST_ENG);
  assign flushing_o   = (state_q == ST_FLUSH);

  // R3: a busy direct-command owner keeps the bus
  a_r3_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_eng_o && (cmd_busy_i || eng_busy_i)) |=> !sel_eng_o);
  // R4: a busy read engine keeps the bus
  a_r4_eng_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_eng_o && eng_busy_i) |=> sel_eng_o);
  // R5: write lock pins ownership to the direct-command port
  a_r5_wlock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_eng_o && wlock_i) |=> !sel_eng_o);
endmodule

// File: rtl/flash_owner_arb.sv
module flash_owner_arb #(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            own_cmd_i,
  input  logic            wlock_i,
  input  logic [NBUF-1:0] flush_i,
  input  logic            cmd_busy_i,
  input  logic            eng_busy_i,
  input  logic            cmd_cs_n_i,
  input  logic            eng_cs_n_i,
  output logic            sel_eng_o,
  output logic            busy_o,
  output logic [NBUF-1:0] inval_o
);
  logic bus_idle;
  logic auto_flush;
  logic flushing;

  assign bus_idle = cmd_cs_n_i && eng_cs_n_i;

  own_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .own_cmd_i    (own_cmd_i),
    .wlock_i      (wlock_i),
    .cmd_busy_i   (cmd_busy_i),
    .eng_busy_i   (eng_busy_i),
    .bus_idle_i   (bus_idle),
    .auto_flush_o (auto_flush),
    .sel_eng_o    (sel_eng_o),
    .flushing_o   (flushing)
  );

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
    flush_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i[gi]),
      .auto_i  (auto_flush),
      .inval_o (inval_o[gi])
    );
  end

  assign busy_o = eng_busy_i || flushing;

  // R8: the mux select moves only after an edge with both chip-selects idle
  a_r8_switch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_eng_o) |-> $past(cmd_cs_n_i && eng_cs_n_i));
  // R9: ownership reaches the read engine only after a full invalidate cycle
  a_r9_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_eng_o) |-> $past(&inval_o));
endmodule

// File: tb/sim_flash_owner_arb.sv
`timescale 1ns/1ps
module sim_flash_owner_arb;
  localparam int NB = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic own_cmd = 1'b1, wlock = 1'b0, cmd_busy = 1'b0, eng_busy = 1'b0;
  logic cmd_cs_n = 1'b1, eng_cs_n = 1'b1;
  logic [NB-1:0] flush = '0;
  logic sel, busy;
  logic [NB-1:0] inval;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_owner_arb #(.NBUF(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .own_cmd_i(own_cmd), .wlock_i(wlock),
    .flush_i(flush), .cmd_busy_i(cmd_busy), .eng_busy_i(eng_busy),
    .cmd_cs_n_i(cmd_cs_n), .eng_cs_n_i(eng_cs_n),
    .sel_eng_o(sel), .busy_o(busy), .inval_o(inval)
  );

  // Behavioural reference: owner phase 0 direct, 1 flushing, 2 engine
  int m_phase;
  logic [NB-1:0] m_inval, m_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_inval <= '1; m_prev <= '0;
    end else begin
      bit ok_eng, ok_cmd;
      ok_eng = !own_cmd && !wlock && !cmd_busy && !eng_busy && cmd_cs_n && eng_cs_n;
      ok_cmd = own_cmd && !eng_busy && cmd_cs_n && eng_cs_n;
      m_inval <= (flush & ~m_prev) | ((m_phase == 0 && ok_eng) ? '1 : '0);
      m_prev  <= flush;
      if (m_phase == 0 && ok_eng) m_phase <= 1;
      else if (m_phase == 1) m_phase <= ok_eng ? 2 : 0;
      else if (m_phase == 2 && ok_cmd) m_phase <= 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 sel_eng_o", int'(sel), int'(m_phase == 2));
    chk("R6 inval_o", int'(inval), int'(m_inval));
    chk("R7 busy_o", int'(busy), int'(eng_busy || m_phase == 1));
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    chk("R1 reset sel", int'(sel), 0);
    chk("R1 reset inval", int'(inval), 3);
    chk("R1 reset busy", int'(busy), 0);
    tick(1);
    chk("R1 inval clears", int'(inval), 0);

    flush[0] = 1'b1; tick(1);
    chk("R6 single buffer pulse", int'(inval), 1);
    tick(1);
    chk("R6 held level silent", int'(inval), 0);
    flush[0] = 1'b0; tick(2);

    own_cmd = 1'b0; wlock = 1'b1; tick(5);
    chk("R5 lock holds", int'(sel), 0);
    wlock = 1'b0; cmd_busy = 1'b1; tick(4);
    chk("R3 cmd busy holds", int'(sel), 0);
    cmd_busy = 1'b0; eng_cs_n = 1'b0; tick(4);
    chk("R3 cs low holds", int'(sel), 0);
    chk("R8 cs low no move", int'(sel), 0);

    eng_cs_n = 1'b1; tick(1);
    chk("R2 flush cycle inval", int'(inval), 3);
    chk("R7 busy in flush", int'(busy), 1);
    eng_busy = 1'b1; tick(1);
    chk("R3 aborted handover", int'(sel), 0);
    eng_busy = 1'b0; tick(1);
    chk("R9 reflush", int'(inval), 3);
    tick(1);
    chk("R2 engine owns", int'(sel), 1);

    flush = 2'b11; tick(1);
    chk("R6 both pulse", int'(inval), 3);
    chk("R2 engine kept", int'(sel), 1);
    flush = 2'b00;
    own_cmd = 1'b1; eng_busy = 1'b1; tick(3);
    chk("R4 busy engine holds", int'(sel), 1);
    chk("R7 busy follows engine", int'(busy), 1);
    eng_busy = 1'b0; cmd_cs_n = 1'b0; tick(3);
    chk("R4 cs low holds", int'(sel), 1);
    cmd_cs_n = 1'b1; tick(1);
    chk("R8 returns when idle", int'(sel), 0);
    chk("R7 idle busy", int'(busy), 0);
    tick(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule